// File: doc/BRIEF.md
# Latched Channel Select Controller

This block is the digital control path of an eight-way analog channel selector that sits on a processor bus. A processor write presents a channel address and an enable bit while an active-low write strobe is low. While the strobe is low the held selection follows the inputs. When the strobe rises, the selection present just before the rise stays held until the next write. An active-low master clear turns every switch-drive output off and wipes the held selection.

The held selection is decoded into one-hot switch-drive outputs. Whenever the driven selection would move from one active channel to another, all outputs are first forced off for a programmable number of clock cycles, so that two switches are never closed together. A status output is high during that gap.

A parameter picks one of two modes. Single-ended mode has eight outputs and uses three address bits. Paired mode has four outputs and uses the two low address bits; each output drives both switches of a pair. The strobe and the clear release are synchronised to the block clock. The address and enable are delayed through the same number of stages as the strobe, so they stay aligned with it.

Top module: `latched_chan_sel`

## Requirements
- R1: While `wr_n` is low, the outputs follow `addr`/`en`. A change on those inputs appears on `sw_on` 4 clock edges after it is applied (2 sync stages, 1 capture register, 1 drive register), plus any gap from R8. No strobe rise is needed.
- R2: After `wr_n` rises, the selection sampled just before the rise stays in force. Later changes on `addr` and `en` while `wr_n` is high have no effect on `sw_on`.
- R3: While `clr_n` is low, `sw_on` is all zero. The clear acts asynchronously and overrides `wr_n`, `addr` and `en`.
- R4: After `clr_n` returns high, `sw_on` stays all zero until a write loads a new selection.
- R5: A held enable of 0 forces `sw_on` to all zero, whatever the held address.
- R6: In single-ended mode (`PAIRED`=0) with the held enable at 1, address value k (0..7) drives only bit k of `sw_on`. At most one bit of `sw_on` is ever high.
- R7: In paired mode (`PAIRED`=1), `sw_on` is 4 bits wide and only `addr[1:0]` is decoded: value k drives only bit k. `addr[2]` is ignored.
- R8: When the selection moves from one active output to a different active output, `sw_on` is all zero for exactly `GAP_CYCLES` cycles (default 2) before the new bit rises. Old and new bits are never high together.
- R9: A move to "all off" (enable 0), or from "all off" to an active output, takes effect with no gap.
- R10: `bbm_busy` is high exactly in the cycles of an R8 gap, and `sw_on` is all zero whenever it is high.
- R11: The block is specified for these minimum input timings:
  - strobe low width of 100 ns;
  - address/enable setup to the strobe rise of 100 ns;
  - hold after the rise of 10 ns;
  - clear low width of 100 ns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| clr_n | input | 1 | Master clear, active low, asynchronous assert |
| wr_n | input | 1 | Write strobe, active low; selection follows inputs while low |
| addr | input | 3 | Channel address (paired mode uses bits 1:0) |
| en | input | 1 | Selection enable |
| sw_on | output | 8 (single) / 4 (paired) | One-hot switch-drive outputs |
| bbm_busy | output | 1 | High during a break-before-make gap |

## Verification
The assertions check the following on every cycle:
- that the drive vector is never more than one-hot;
- that an active output never hands over directly to another active output;
- that the busy flag only accompanies all-off outputs;
- that a zero held enable clears the outputs;
- that the capture register holds while the synchronised strobe is high and follows while it is low;
- that outputs stay off during the synchronised clear release.

Only the bench's scenarios can show the following:
- the exact gap length;
- the absence of a gap on enable changes;
- the asynchronous clear taking effect without a clock;
- the address-to-output decoding in both modes;
- the fact that inputs changed after the strobe rise have no effect.

A timing monitor in the bench confirms that its own stimulus respects the R11 limits.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    // Mode selector used for readability in parameter checks
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_PAIRED = 1'b1
    } chsel_mode_e;

    // Address width for a given mode
    function automatic int addr_bits(input int paired);
        return (paired != 0) ? 2 : 3;
    endfunction

    // Number of drive outputs for a given mode
    function automatic int out_count(input int paired);
        return 1 << addr_bits(paired);
    endfunction

endpackage

// File: rtl/chsel_rst_sync.sv
module chsel_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic rst_n
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } rs_t;

    rs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n = st_q.sh[STAGES-1];

endmodule

// File: rtl/chsel_capture.sv
module chsel_capture #(
    parameter int AW     = 3,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] held_addr,
    output logic          held_en
);

    typedef struct packed {
        logic          wr_n;
        logic          en;
        logic [AW-1:0] a;
    } samp_t;

    typedef struct packed {
        samp_t [STAGES-1:0] pipe;
        logic               en;
        logic [AW-1:0]      a;
    } cap_t;

    localparam samp_t SAMP_IDLE = '{wr_n: 1'b1, en: 1'b0, a: '0};
    localparam cap_t  CAP_RST   = '{pipe: {STAGES{SAMP_IDLE}}, en: 1'b0, a: '0};

    cap_t  st_d, st_q;
    samp_t last;

    assign last = st_q.pipe[STAGES-1];

    always_comb begin
        st_d = st_q;
        // Strobe and data travel the same number of stages
        st_d.pipe[0] = '{wr_n: wr_n, en: en, a: addr};
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        // Level-sensitive capture: follow while strobe low, hold otherwise
        if (!last.wr_n) begin
            st_d.en = last.en;
            st_d.a  = last.a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CAP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_addr = st_q.a;
    assign held_en   = st_q.en;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        last.wr_n |=> (held_addr == $past(held_addr) && held_en == $past(held_en))); // R2

    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !last.wr_n |=> (held_addr == $past(last.a) && held_en == $past(last.en))); // R1

endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
    parameter int AW  = 3,
    parameter int NCH = 8
) (
    input  logic [AW-1:0]  sel,
    input  logic           en,
    output logic [NCH-1:0] want
);

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign want[g] = en && (sel == AW'(g));
    end

endmodule

// File: rtl/chsel_bbm.sv
module chsel_bbm #(
    parameter int NCH = 8,
    parameter int GAP = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] want,
    output logic [NCH-1:0] drv,
    output logic           busy
);

    localparam int CW = $clog2(GAP + 1);

    typedef struct packed {
        logic [NCH-1:0] drv;
        logic [CW-1:0]  cnt;
    } bbm_t;

    bbm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            // Gap in progress: keep everything off, load target at the end
            st_d.drv = '0;
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.drv = want;
            end
        end else if (want != st_q.drv) begin
            if (st_q.drv == '0 || want == '0) begin
                st_d.drv = want;
            end else begin
                st_d.drv = '0;
                st_d.cnt = CW'(GAP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv  = st_q.drv;
    assign busy = (st_q.cnt != '0);

    AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv)); // R6

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (drv != '0 && $past(drv) != '0) |-> drv == $past(drv)); // R8

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(GAP)); // R8

    AST_BUSY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> drv == '0); // R10

endmodule

// File: rtl/latched_chan_sel.sv
module latched_chan_sel #(
    parameter int PAIRED      = 0,
    parameter int GAP_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              clr_n,
    input  logic                              wr_n,
    input  logic [2:0]                        addr,
    input  logic                              en,
    output logic [chsel_pkg::out_count(PAIRED)-1:0] sw_on,
    output logic                              bbm_busy
);

    import chsel_pkg::*;

    localparam int AW  = addr_bits(PAIRED);
    localparam int NCH = out_count(PAIRED);
    localparam chsel_mode_e MODE = (PAIRED != 0) ? MODE_PAIRED : MODE_SINGLE;

    logic           core_rst_n;
    logic [AW-1:0]  held_addr;
    logic           held_en;
    logic [NCH-1:0] want;
    logic [AW-1:0]  addr_sel;

    if (MODE == MODE_PAIRED) begin : g_paired
        logic unused_addr_hi;
        assign unused_addr_hi = addr[2];
        assign addr_sel       = addr[AW-1:0];
    end else begin : g_single
        assign addr_sel = addr;
    end

    chsel_rst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_rst_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .rst_n (core_rst_n)
    );

    chsel_capture #(
        .AW     (AW),
        .STAGES (SYNC_STAGES)
    ) u_capture (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .wr_n      (wr_n),
        .en        (en),
        .addr      (addr_sel),
        .held_addr (held_addr),
        .held_en   (held_en)
    );

    chsel_decode #(
        .AW  (AW),
        .NCH (NCH)
    ) u_decode (
        .sel  (held_addr),
        .en   (held_en),
        .want (want)
    );

    chsel_bbm #(
        .NCH (NCH),
        .GAP (GAP_CYCLES)
    ) u_bbm (
        .clk   (clk),
        .rst_n (core_rst_n),
        .want  (want),
        .drv   (sw_on),
        .busy  (bbm_busy)
    );

    AST_EN_OFF: assert property (@(posedge clk) disable iff (!core_rst_n)
        !held_en |=> sw_on == '0); // R5

    AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!clr_n)
        !core_rst_n |-> sw_on == '0); // R4

endmodule

// File: tb/latched_chan_sel_bench.sv
`timescale 1ns/1ps
module latched_chan_sel_bench;

    logic       clk   = 1'b0;
    logic       clr_n = 1'b1;
    logic       wr_n  = 1'b1;
    logic [2:0] addr  = 3'd0;
    logic       en    = 1'b0;
    logic [7:0] sw;
    logic [3:0] sw_pr;
    logic       busy, busy_pr;

    int n_checks = 0;
    int n_errors = 0;
    int viol     = 0;

    always #10 clk = ~clk;  // 50 MHz

    latched_chan_sel #(.PAIRED(0)) u_latched_chan_sel (
        .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .addr(addr), .en(en),
        .sw_on(sw), .bbm_busy(busy));

    latched_chan_sel #(.PAIRED(1)) u_latched_chan_sel_pr (
        .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .addr(addr), .en(en),
        .sw_on(sw_pr), .bbm_busy(busy_pr));

    // Input timing monitor (R11)
    realtime t_wf = -1.0e6, t_wr = -1.0e6, t_data = -1.0e6, t_cf = -1.0e6;
    always @(negedge wr_n) t_wf = $realtime;
    always @(posedge wr_n) begin
        if ($realtime - t_wf < 100.0) viol++;
        if ($realtime - t_data < 100.0) viol++;
        t_wr = $realtime;
    end
    always @(addr or en) begin
        if (wr_n && ($realtime - t_wr < 10.0)) viol++;
        t_data = $realtime;
    end
    always @(negedge clr_n) t_cf = $realtime;
    always @(posedge clr_n) if ($realtime - t_cf < 100.0) viol++;

    typedef struct packed {
        logic [2:0] a;
        logic       e;
        logic [7:0] x8;
        logic [3:0] x4;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 1'b1, 8'h01, 4'h1},
        '{3'd1, 1'b1, 8'h02, 4'h2},
        '{3'd2, 1'b1, 8'h04, 4'h4},
        '{3'd3, 1'b1, 8'h08, 4'h8},
        '{3'd4, 1'b1, 8'h10, 4'h1},
        '{3'd5, 1'b1, 8'h20, 4'h2},
        '{3'd6, 1'b1, 8'h40, 4'h4},
        '{3'd7, 1'b1, 8'h80, 4'h8},
        '{3'd5, 1'b0, 8'h00, 4'h0},
        '{3'd7, 1'b1, 8'h80, 4'h8},
        '{3'd0, 1'b0, 8'h00, 4'h0},
        '{3'd2, 1'b1, 8'h04, 4'h4}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic e);
        @(negedge clk);
        addr = a;
        en   = e;
        wr_n = 1'b0;
        repeat (6) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    // Write while watching every cycle of the main instance
    task automatic watched_write(input logic [2:0] a, input logic e, input logic [7:0] exp_new,
                                 output int zeros, output int busyc, output int ovl);
        zeros = 0;
        busyc = 0;
        ovl   = 0;
        fork
            do_write(a, e);
            begin
                bit seen = 1'b0;
                repeat (24) begin
                    @(negedge clk);
                    if (sw == exp_new) seen = 1'b1;
                    if (!seen && sw == 8'h00) zeros++;
                    if ($countones(sw) > 1) ovl++;
                    if (busy) busyc++;
                end
            end
        join
    endtask

    initial begin
        #(20.0 * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int z, b, o;
        #1 clr_n = 1'b0;
        repeat (10) @(negedge clk);
        clr_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 reset state main", sw, 8'h00);
        check("R4 reset state paired", {4'h0, sw_pr}, 8'h00);
        check("R10 busy idle after reset", {7'h0, busy}, 8'h00);

        // Vector table: R5 (enable off), R6 single decode, R7 paired decode
        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].a, VEC[i].e);
            repeat (8) @(negedge clk);
            check(VEC[i].e ? "R6 single decode" : "R5 enable off main", sw, VEC[i].x8);
            check(VEC[i].e ? "R7 paired decode" : "R5 enable off paired", {4'h0, sw_pr}, {4'h0, VEC[i].x4});
        end

        // R1: transparent while strobe low
        @(negedge clk);
        addr = 3'd2; en = 1'b1; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 follow while low", sw, 8'h04);
        addr = 3'd6;
        repeat (8) @(negedge clk);
        check("R1 follow new addr without rise", sw, 8'h40);
        wr_n = 1'b1;
        @(negedge clk);

        // R2: changes after the rise ignored
        addr = 3'd1; en = 1'b0;
        repeat (10) @(negedge clk);
        check("R2 hold after rise main", sw, 8'h40);
        check("R2 hold after rise paired", {4'h0, sw_pr}, 8'h04);

        // R8 / R10: break-before-make gap between active channels
        watched_write(3'd1, 1'b1, 8'h02, z, b, o);
        check("R8 gap length", 8'(z), 8'd2);
        check("R8 no overlap", 8'(o), 8'd0);
        check("R10 busy cycles", 8'(b), 8'd2);
        check("R8 new channel", sw, 8'h02);

        // R9: enable off and on without a gap
        watched_write(3'd1, 1'b0, 8'h00, z, b, o);
        check("R9 off no busy", 8'(b), 8'd0);
        check("R9 off result", sw, 8'h00);
        watched_write(3'd3, 1'b1, 8'h08, z, b, o);
        check("R9 on no busy", 8'(b), 8'd0);
        check("R9 on result", sw, 8'h08);

        // R3: asynchronous clear with priority
        @(negedge clk);
        clr_n = 1'b0;
        #1;
        check("R3 async clear main", sw, 8'h00);
        check("R3 async clear paired", {4'h0, sw_pr}, 8'h00);
        @(negedge clk);
        addr = 3'd5; en = 1'b1; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R3 clear overrides strobe", sw, 8'h00);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        clr_n = 1'b1;
        repeat (12) @(negedge clk);
        check("R4 off after release main", sw, 8'h00);
        check("R4 off after release paired", {4'h0, sw_pr}, 8'h00);
        do_write(3'd5, 1'b1);
        repeat (8) @(negedge clk);
        check("R4 write after release", sw, 8'h20);

        check("R11 stimulus timing violations", 8'(viol), 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule